// File: doc/BRIEF.md
# Two-Thread Partitioned Recombining Queue

This block is a buffer of `DEPTH` entries that two hardware threads share, of the kind that holds decoded operations between pipeline stages. Each thread pushes opaque payloads through its own valid/ready enqueue port. A single valid/ready dequeue port delivers entries, and each entry is tagged with the thread that wrote it. When both threads run, the storage is cut into two fixed halves, one per thread. A thread that stops draining or fills its half therefore never takes space from the other. When only one thread runs, the halves are joined, and that thread sees a plain queue of full depth and full rate.

The operating mode is set through a request pin and changes only once the queue is empty. While a request waits for the drain, a busy pin is high and both enqueue ports refuse data. When both threads hold entries, the dequeue side takes them in turn. When only one thread holds entries, that thread gets every dequeue.

Back-pressure rules are as follows. An enqueue transfer occurs on a rising edge where that thread's valid and ready are both high. A dequeue transfer occurs where `out_valid` and `out_ready` are both high. Ready does not depend on valid. The data, tag and valid outputs depend only on registered state. The selected thread changes only after a dequeue, or when the other thread's first entry arrives.

Top module: `smt_part_queue`

## Requirements
- R1: Mode code 2'b00 (and 2'b11) is multi-thread mode. In it, each thread holds at most DEPTH/2 entries, and a thread's ready is high exactly when it holds fewer than DEPTH/2 entries and no mode request is pending.
- R2: In mode 2'b01 (thread 0 alone) or 2'b10 (thread 1 alone), the active thread may hold all DEPTH entries. Its ready is high exactly when it holds fewer than DEPTH entries and no request is pending.
- R3: Entries of one thread leave in the order they entered. Each entry's payload and its thread tag (`out_tid`, 0 or 1) come out unchanged.
- R4: When both threads hold entries, the thread served alternates on every dequeue. After reset, thread 0 goes first.
- R5: When only one thread holds entries, that thread is served on every cycle with `out_ready` high, so one entry leaves per cycle.
- R6: In multi-thread mode, both threads may enqueue in the same cycle and both entries are stored.
- R7: A mode request raises `mode_busy` from the next cycle. The request takes effect on the first clock edge at which the queue is empty, and `mode_busy` then falls. While busy, both readies are low. A request made while one is pending is ignored.
- R8: In a single-thread mode, the other thread's ready is low and its pushes are discarded. Each cycle in which it asserts valid raises `err_inactive` for the following cycle.
- R9: After reset, the mode is multi-thread, both occupancy outputs are 0, `out_valid` is low, both readies are high and `mode_busy` is low.
- R10: In multi-thread mode, a thread whose half is full and not draining does not stop the other thread from enqueueing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req_vld | input | 1 | Mode request strobe |
| mode_req | input | 2 | Requested mode code |
| mode_cur | output | 2 | Mode now in force |
| mode_busy | output | 1 | Mode request waiting for drain |
| t0_valid | input | 1 | Thread 0 enqueue valid |
| t0_ready | output | 1 | Thread 0 enqueue ready |
| t0_data | input | W | Thread 0 payload |
| t1_valid | input | 1 | Thread 1 enqueue valid |
| t1_ready | output | 1 | Thread 1 enqueue ready |
| t1_data | input | W | Thread 1 payload |
| out_valid | output | 1 | Dequeue valid |
| out_ready | input | 1 | Dequeue ready |
| out_data | output | W | Dequeued payload |
| out_tid | output | 1 | Thread tag of dequeued entry |
| occ0 | output | clog2(DEPTH+1) | Thread 0 occupancy |
| occ1 | output | clog2(DEPTH+1) | Thread 1 occupancy |
| err_inactive | output | 1 | Push by inactive thread seen last cycle |

## Verification
The readies and the dequeue outputs are combinational from registered state. They are checked within the cycle that follows the edge that changed that state. Occupancy, mode and busy change on the edge that samples the stimulus, and they are compared one cycle after that stimulus is driven. `err_inactive` is registered, so it is expected exactly one cycle after the offending valid. The bench drives inputs after the falling edge and compares shortly afterwards against a model that is advanced once per rising edge, so each result is checked in the cycle it is due.

// File: rtl/tq_pkg.sv
package tq_pkg;
  typedef enum logic [1:0] {
    TQ_MT  = 2'b00,
    TQ_ST0 = 2'b01,
    TQ_ST1 = 2'b10
  } tq_mode_e;
endpackage

// File: rtl/tq_ring_ctl.sv
// Per-thread ring pointers over a window whose size follows the mode.
module tq_ring_ctl #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          half,
  input  logic          push,
  input  logic          pop,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] rptr,
  output logic [CW-1:0] occ
);
  localparam logic [PW-1:0] LAST_HALF = PW'(DEPTH / 2 - 1);
  localparam logic [PW-1:0] LAST_FULL = PW'(DEPTH - 1);

  logic [PW-1:0] last;
  assign last = half ? LAST_HALF : LAST_FULL;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p, input logic [PW-1:0] lim);
    return (p == lim) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
    end else if (clr) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
    end else begin
      if (push) wptr <= step(wptr, last);
      if (pop)  rptr <= step(rptr, last);
      case ({push, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/tq_pingpong_arb.sv
// Alternates between threads when both have entries; else serves the one that does.
module tq_pingpong_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic req0,
  input  logic req1,
  input  logic take,
  output logic any,
  output logic gnt
);
  logic last;

  assign any = req0 | req1;
  assign gnt = (req0 && req1) ? ~last : req1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           last <= 1'b1;
    else if (take && any) last <= gnt;
  end
endmodule

// File: rtl/tq_mode_ctl.sv
// Holds a mode request until the queue is empty, then applies it.
module tq_mode_ctl
  import tq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_vld,
  input  logic [1:0] req_mode,
  input  logic       empty,
  output logic [1:0] mode,
  output logic       busy,
  output logic       clr
);
  logic [1:0] tgt;

  assign clr = busy && empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= TQ_MT;
      tgt  <= TQ_MT;
      busy <= 1'b0;
    end else if (clr) begin
      mode <= tgt;
      busy <= 1'b0;
    end else if (req_vld && !busy) begin
      tgt  <= req_mode;
      busy <= 1'b1;
    end
  end
endmodule

// File: rtl/smt_part_queue.sv
module smt_part_queue
  import tq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int W = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_req_vld,
  input  logic [1:0]    mode_req,
  output logic [1:0]    mode_cur,
  output logic          mode_busy,
  input  logic          t0_valid,
  output logic          t0_ready,
  input  logic [W-1:0]  t0_data,
  input  logic          t1_valid,
  output logic          t1_ready,
  input  logic [W-1:0]  t1_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic          out_tid,
  output logic [CW-1:0] occ0,
  output logic [CW-1:0] occ1,
  output logic          err_inactive
);
  localparam logic [PW-1:0] BASE_HI  = PW'(DEPTH / 2);
  localparam logic [CW-1:0] CAP_HALF = CW'(DEPTH / 2);
  localparam logic [CW-1:0] CAP_FULL = CW'(DEPTH);

  logic          half, clr, gnt, any, take;
  logic [1:0]    act, push, pop, nonempty;
  logic [CW-1:0] cap;
  logic [PW-1:0] wptr [2];
  logic [PW-1:0] rptr [2];
  logic [CW-1:0] occ  [2];
  logic [PW-1:0] base [2];
  logic [W-1:0]  mem  [DEPTH];

  tq_mode_ctl u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_vld  (mode_req_vld),
    .req_mode (mode_req),
    .empty    (occ[0] == '0 && occ[1] == '0),
    .mode     (mode_cur),
    .busy     (mode_busy),
    .clr      (clr)
  );

  assign act[0] = (mode_cur != TQ_ST1);
  assign act[1] = (mode_cur != TQ_ST0);
  assign half   = act[0] && act[1];
  assign cap    = half ? CAP_HALF : CAP_FULL;

  // Thread 1 owns the upper half only while partitioned.
  assign base[0] = '0;
  assign base[1] = half ? BASE_HI : '0;

  assign t0_ready = act[0] && !mode_busy && (occ[0] < cap);
  assign t1_ready = act[1] && !mode_busy && (occ[1] < cap);
  assign push[0]  = t0_valid && t0_ready;
  assign push[1]  = t1_valid && t1_ready;

  tq_pingpong_arb u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req0  (nonempty[0]),
    .req1  (nonempty[1]),
    .take  (out_ready),
    .any   (any),
    .gnt   (gnt)
  );

  assign take   = any && out_ready;
  assign pop[0] = take && !gnt;
  assign pop[1] = take && gnt;

  for (genvar t = 0; t < 2; t++) begin : g_thr
    assign nonempty[t] = (occ[t] != '0);
    tq_ring_ctl #(.DEPTH(DEPTH)) u_ring (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .half  (half),
      .push  (push[t]),
      .pop   (pop[t]),
      .wptr  (wptr[t]),
      .rptr  (rptr[t]),
      .occ   (occ[t])
    );
  end

  always_ff @(posedge clk) begin
    if (push[0]) mem[base[0] + wptr[0]] <= t0_data;
    if (push[1]) mem[base[1] + wptr[1]] <= t1_data;
  end

  assign out_valid = any;
  assign out_tid   = gnt;
  assign out_data  = mem[base[gnt] + rptr[gnt]];
  assign occ0      = occ[0];
  assign occ1      = occ[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_inactive <= 1'b0;
    else        err_inactive <= (!act[0] && t0_valid) || (!act[1] && t1_valid);
  end
endmodule

// File: rtl/tq_checker.sv
module tq_checker
  import tq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode_cur,
  input logic          mode_busy,
  input logic          t0_valid,
  input logic          t0_ready,
  input logic          t1_valid,
  input logic          t1_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_tid,
  input logic [CW-1:0] occ0,
  input logic [CW-1:0] occ1,
  input logic          err_inactive
);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  p_half_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cur == TQ_MT) |-> (occ0 <= HALF && occ1 <= HALF));

  p_ready_half_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cur == TQ_MT && !mode_busy) |-> (t0_ready == (occ0 < HALF)));

  p_full_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (occ0 <= FULL && occ1 <= FULL));

  p_pingpong_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && occ0 != '0 && occ1 != '0) |=> (out_tid != $past(out_tid)));

  p_solo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (occ0 != '0 && occ1 == '0) |-> (out_valid && !out_tid));

  p_busy_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_busy |-> (!t0_ready && !t1_ready));

  p_switch_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cur != $past(mode_cur)) |-> ($past(occ0) == '0 && $past(occ1) == '0));

  p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cur == TQ_ST0) |-> !t1_ready);

  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cur == TQ_ST0 && t1_valid) |=> err_inactive);
endmodule

bind smt_part_queue tq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_cur     (mode_cur),
  .mode_busy    (mode_busy),
  .t0_valid     (t0_valid),
  .t0_ready     (t0_ready),
  .t1_valid     (t1_valid),
  .t1_ready     (t1_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_tid      (out_tid),
  .occ0         (occ0),
  .occ1         (occ1),
  .err_inactive (err_inactive)
);

// File: tb/smt_part_queue_tb.sv
module smt_part_queue_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int W = 8;
  localparam int CW = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_req_vld = 1'b0;
  logic [1:0]    mode_req = 2'b00;
  logic [1:0]    mode_cur;
  logic          mode_busy;
  logic          t0_valid = 1'b0, t1_valid = 1'b0, out_ready = 1'b0;
  logic          t0_ready, t1_ready, out_valid, out_tid, err_inactive;
  logic [W-1:0]  t0_data = '0, t1_data = '0, out_data;
  logic [CW-1:0] occ0, occ1;

  smt_part_queue #(.DEPTH(DEPTH), .W(W)) u_dut (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Bench model of the requirements.
  logic [W-1:0] mq0[$];
  logic [W-1:0] mq1[$];
  logic [1:0]   mmode = 2'b00, mtgt = 2'b00;
  bit           mpend = 0, mlast = 1, merr = 0;
  logic [W-1:0] d0 = 8'h00, d1 = 8'h80;

  // stimulus vectors {t0_valid, t1_valid, out_ready}, multi-thread mode
  localparam logic [2:0] VEC [28] = '{
    3'b110, 3'b110, 3'b110, 3'b111, 3'b111, 3'b111, 3'b011, 3'b011,
    3'b001, 3'b101, 3'b101, 3'b001, 3'b001, 3'b100, 3'b100, 3'b100,
    3'b100, 3'b100, 3'b111, 3'b011, 3'b011, 3'b000, 3'b001, 3'b001,
    3'b001, 3'b001, 3'b001, 3'b001
  };

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v0, bit v1, bit ordy, bit rqv, logic [1:0] rq, string tag);
    bit half, er0, er1, ev, etid, was_empty;
    int cap;
    @(negedge clk);
    t0_valid = v0; t0_data = d0;
    t1_valid = v1; t1_data = d1;
    out_ready = ordy; mode_req_vld = rqv; mode_req = rq;
    #2;
    half = !(mmode == 2'b01 || mmode == 2'b10);
    cap  = half ? DEPTH / 2 : DEPTH;
    er0  = (mmode != 2'b10) && !mpend && (mq0.size() < cap);
    er1  = (mmode != 2'b01) && !mpend && (mq1.size() < cap);
    ev   = (mq0.size() != 0) || (mq1.size() != 0);
    etid = (mq0.size() != 0 && mq1.size() != 0) ? !mlast : (mq0.size() == 0 && mq1.size() != 0);
    chk(tag, "t0_ready", int'(t0_ready), int'(er0));
    chk(tag, "t1_ready", int'(t1_ready), int'(er1));
    chk(tag, "out_valid", int'(out_valid), int'(ev));
    if (ev) begin
      chk(tag, "out_tid", int'(out_tid), int'(etid));
      chk(tag, "out_data", int'(out_data), etid ? int'(mq1[0]) : int'(mq0[0]));
    end
    chk(tag, "occ0", int'(occ0), mq0.size());
    chk(tag, "occ1", int'(occ1), mq1.size());
    chk(tag, "mode_busy", int'(mode_busy), int'(mpend));
    chk(tag, "mode_cur", int'(mode_cur), int'(mmode));
    chk(tag, "err_inactive", int'(err_inactive), int'(merr));
    // advance the model to the next rising edge
    was_empty = (mq0.size() == 0) && (mq1.size() == 0);
    merr = (mmode == 2'b01 && v1) || (mmode == 2'b10 && v0);
    if (ev && ordy) begin
      if (etid) void'(mq1.pop_front());
      else      void'(mq0.pop_front());
      mlast = etid;
    end
    if (v0 && er0) begin mq0.push_back(d0); d0 = d0 + 1'b1; end
    if (v1 && er1) begin mq1.push_back(d1); d1 = d1 + 1'b1; end
    if (mpend && was_empty) begin mmode = mtgt; mpend = 0; end
    else if (rqv && !mpend) begin mtgt = rq; mpend = 1; end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // R9: state held in reset
    repeat (3) @(negedge clk);
    chk("R9", "occ0", int'(occ0), 0);
    chk("R9", "occ1", int'(occ1), 0);
    chk("R9", "out_valid", int'(out_valid), 0);
    chk("R9", "mode_cur", int'(mode_cur), 0);
    chk("R9", "t0_ready", int'(t0_ready), 1);
    chk("R9", "t1_ready", int'(t1_ready), 1);
    chk("R9", "mode_busy", int'(mode_busy), 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 2'b00, "R9");

    // table walk: alternation (R4) plus order and tags (R3), both pushes (R6)
    foreach (VEC[i]) step(VEC[i][2], VEC[i][1], VEC[i][0], 0, 2'b00, "R4");

    // R6: both threads enqueue together, nothing drains
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 2'b00, "R6");
    // R1: thread 0 reaches its half and ready falls
    for (int i = 0; i < 2; i++) step(1, 0, 0, 0, 2'b00, "R1");
    // R10: thread 0 full and stalled, thread 1 still enqueues
    step(1, 1, 0, 0, 2'b00, "R10");
    step(1, 0, 0, 0, 2'b00, "R1");
    // R4: drain both halves alternately
    for (int i = 0; i < 9; i++) step(0, 0, 1, 0, 2'b00, "R4");

    // R7: request single thread 0 with entries present
    step(1, 0, 0, 0, 2'b00, "R7");
    step(1, 1, 0, 1, 2'b01, "R7");
    step(1, 1, 0, 1, 2'b10, "R7");
    step(1, 0, 0, 0, 2'b00, "R7");
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 2'b00, "R7");

    // R2: thread 0 alone fills all entries; R8: thread 1 pushes ignored
    for (int i = 0; i < 9; i++) step(1, 0, 0, 0, 2'b00, "R2");
    step(0, 1, 0, 0, 2'b00, "R8");
    step(0, 1, 0, 0, 2'b00, "R8");
    step(0, 0, 0, 0, 2'b00, "R8");
    // R3: drain in order; R5: one per cycle while refilling
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 2'b00, "R3");
    for (int i = 0; i < 6; i++) step(1, 0, 1, 0, 2'b00, "R5");
    for (int i = 0; i < 10; i++) step(0, 0, 1, 0, 2'b00, "R3");

    // single thread 1
    step(0, 0, 0, 1, 2'b10, "R7");
    step(0, 0, 0, 0, 2'b00, "R7");
    step(0, 0, 0, 0, 2'b00, "R7");
    for (int i = 0; i < 9; i++) step(1, 1, 0, 0, 2'b00, "R2");
    step(1, 0, 0, 0, 2'b00, "R8");
    step(0, 0, 0, 0, 2'b00, "R8");
    for (int i = 0; i < 4; i++) step(0, 1, 1, 0, 2'b00, "R5");
    for (int i = 0; i < 10; i++) step(0, 0, 1, 0, 2'b00, "R3");

    // back to multi-thread via code 2'b11
    step(0, 0, 0, 1, 2'b11, "R7");
    for (int i = 0; i < 2; i++) step(0, 0, 0, 0, 2'b00, "R7");
    for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 2'b00, "R1");
    for (int i = 0; i < 9; i++) step(0, 0, 1, 0, 2'b00, "R4");

    summary();
  end
endmodule